// File: doc/BRIEF.md
# 100 Mb/s Twisted-Pair PCS Transmit Framer

This block sits between a MAC transmit path and the scrambler of a 100 Mb/s twisted-pair physical layer. The MAC offers a frame one byte at a time: preamble octets, start-frame delimiter, addresses, length, payload and check sequence. While it holds `frm_valid` high, the framer pulls bytes with a one-cycle `byte_ack` pulse, at the rate of one byte per two nibble-clock cycles. Every nibble-clock cycle it emits one 5-bit code-group. When the link is quiet, that code-group is idle (`11111`).

When a frame begins, the framer consumes the first preamble octet without encoding it and sends the start-of-stream pair J (`11000`) and K (`10001`) in its place, so the frame keeps its length on the line. Each later byte becomes two data code-groups, low nibble first, through the 4B5B table. At the first byte boundary where `frm_valid` is low, the framer appends the end-of-stream pair T (`01101`) and R (`00111`). It then sends at least `MIN_IDLE` idle code-groups before it will accept the next frame. Code-groups are given in transmit order: bit 4 of `cg_out` is the first bit on the line.

Top module: `pcs_tx_framer`

## Requirements
- R1: While `rst_n` is low, at the following clock edge `cg_out` becomes `11111` and `cg_vld` becomes 0. With `frm_valid` low, `byte_ack` is 0.
- R2: While no frame is in progress and `frm_valid` is low, every code-group is idle `11111` and `byte_ack` stays 0.
- R3: In the first idle-state cycle with `frm_valid` high, `byte_ack` is 1 and that byte is discarded. The next two code-groups are `11000` and then `10001`.
- R4: Each accepted byte after the first is sent as the code-group of bits [3:0] and then that of bits [7:4]. The table maps 0..F to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R5: If the first byte is acknowledged in cycle a, the next byte is acknowledged in cycle a+2, and so on every second cycle while `frm_valid` is high at those points. `byte_ack` is never high in two consecutive cycles.
- R6: If `frm_valid` is low in a cycle where the next byte would be taken, the next two code-groups are `01101` and then `00111`.
- R7: After the `00111` code-group, exactly `MIN_IDLE` idle code-groups are sent before a `11000`, even if `frm_valid` is already high during T, R or the gap. `byte_ack` stays 0 until then.
- R8: From the first clock edge after reset is released, `cg_vld` is 1 in every cycle.
- R9: `byte_ack` is only ever high while `frm_valid` is high.
- R10: A frame of N accepted bytes gives exactly 2N code-groups from J up to the last data code-group, and T follows directly after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | High while the MAC has a frame byte on `frm_byte` |
| frm_byte | input | 8 | Current frame byte, taken at the edge ending a `byte_ack` cycle |
| byte_ack | output | 1 | Current byte is consumed at this edge; the next byte must follow |
| cg_out | output | 5 | Registered code-group, bit 4 transmitted first |
| cg_vld | output | 1 | Code-group strobe, high every cycle out of reset |

## Verification
The embedded properties check the following on every cycle:
- J is always followed by K, T by R, and R by idle.
- `byte_ack` never comes without `frm_valid` and never in back-to-back cycles.
- The stored high nibble stays frozen between loads.
- The gap counter stays in range.
- `cg_vld` holds after reset.

Other behaviours are only visible from the directed scenarios:
- the exact 4B5B value of each nibble and the low-nibble-first order;
- the discarding of the first preamble octet;
- the frame length from J to T;
- the precise ack cadence;
- the exact number of idles that hold off a back-to-back request.

// File: rtl/pcs_txf_pkg.sv
// Package pcs_txf_pkg
// Shared widths, line control code-groups and sequencer types for the
// 100 Mb/s PCS transmit framer. Codes are written in transmit order,
// bit 4 first on the line.
package pcs_txf_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int CG_W   = 5;

    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SSD_K,
        ST_LO,
        ST_HI,
        ST_ESD_R,
        ST_GAP
    } seq_state_e;

    // Which code-group source feeds the output register
    typedef enum logic [2:0] {
        SEL_IDLE,
        SEL_J,
        SEL_K,
        SEL_LO,
        SEL_HI,
        SEL_T,
        SEL_R
    } cg_sel_e;

endpackage

// File: rtl/pcs_txf_enc.sv
// Module pcs_txf_enc
// Purely combinational 4B5B data encoder: maps one nibble onto its 5-bit
// data code-group. Assumes the caller only presents data nibbles; control
// code-groups are produced elsewhere.
module pcs_txf_enc
    import pcs_txf_pkg::*;
(
    input  logic [NIB_W-1:0] nib_i,
    output logic [CG_W-1:0]  cg_o
);

    // Table lookup from nibble to data code-group
    always_comb begin
        unique case (nib_i)
            4'h0: cg_o = 5'b11110;
            4'h1: cg_o = 5'b01001;
            4'h2: cg_o = 5'b10100;
            4'h3: cg_o = 5'b10101;
            4'h4: cg_o = 5'b01010;
            4'h5: cg_o = 5'b01011;
            4'h6: cg_o = 5'b01110;
            4'h7: cg_o = 5'b01111;
            4'h8: cg_o = 5'b10010;
            4'h9: cg_o = 5'b10011;
            4'hA: cg_o = 5'b10110;
            4'hB: cg_o = 5'b10111;
            4'hC: cg_o = 5'b11010;
            4'hD: cg_o = 5'b11011;
            4'hE: cg_o = 5'b11100;
            default: cg_o = 5'b11101;
        endcase
    end

endmodule

// File: rtl/pcs_txf_nib.sv
// Module pcs_txf_nib
// Nibble splitter. On a load cycle it passes the low nibble of the
// incoming byte straight through and keeps the high nibble in a 4-bit
// holding register for the following cycle. Assumes that load and hi_sel
// never coincide, which the sequencer guarantees.
module pcs_txf_nib
    import pcs_txf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              hi_sel_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [NIB_W-1:0]  nib_o
);

    logic [NIB_W-1:0] hi_q;

    // Capture the high nibble of each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (load_i) begin
            hi_q <= byte_i[BYTE_W-1:NIB_W];
        end
    end

    // Choose the nibble to encode in this cycle
    always_comb begin
        nib_o = hi_sel_i ? hi_q : byte_i[NIB_W-1:0];
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(hi_q)); // R4

endmodule

// File: rtl/pcs_txf_seq.sv
// Module pcs_txf_seq
// Frame sequencer. It walks idle -> J/K -> alternating low/high nibbles ->
// T/R -> mandatory idle gap, and it pulls bytes from the MAC with a
// one-cycle acknowledge. Assumes the MAC keeps the next byte on its bus
// from the cycle after each acknowledge, and lowers frm_valid after the
// last byte.
module pcs_txf_seq
    import pcs_txf_pkg::*;
#(
    parameter int MIN_IDLE = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    frm_valid_i,
    output logic    byte_ack_o,
    output logic    load_o,
    output cg_sel_e sel_o
);

    localparam int GAP_W = (MIN_IDLE > 1) ? $clog2(MIN_IDLE) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(MIN_IDLE - 1);

    seq_state_e       state_q, state_d;
    logic [GAP_W-1:0] gap_q, gap_d;

    // Next-state, acknowledge and code-group source decisions
    always_comb begin
        state_d    = state_q;
        gap_d      = gap_q;
        byte_ack_o = 1'b0;
        load_o     = 1'b0;
        sel_o      = SEL_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (frm_valid_i) begin
                    byte_ack_o = 1'b1;
                    sel_o      = SEL_J;
                    state_d    = ST_SSD_K;
                end
            end
            ST_SSD_K: begin
                sel_o   = SEL_K;
                state_d = ST_LO;
            end
            ST_LO: begin
                if (frm_valid_i) begin
                    byte_ack_o = 1'b1;
                    load_o     = 1'b1;
                    sel_o      = SEL_LO;
                    state_d    = ST_HI;
                end else begin
                    sel_o   = SEL_T;
                    state_d = ST_ESD_R;
                end
            end
            ST_HI: begin
                sel_o   = SEL_HI;
                state_d = ST_LO;
            end
            ST_ESD_R: begin
                sel_o   = SEL_R;
                gap_d   = '0;
                state_d = ST_GAP;
            end
            default: begin
                sel_o = SEL_IDLE;
                if (gap_q == GAP_LAST) begin
                    state_d = ST_IDLE;
                end else begin
                    gap_d = gap_q + 1'b1;
                end
            end
        endcase
    end

    // State and gap counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    AST_ACK_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ack_o |-> frm_valid_i); // R9
    AST_ACK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ack_o |=> !byte_ack_o); // R5
    AST_GAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (gap_q <= GAP_LAST)); // R7
    AST_NO_ACK_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP || state_q == ST_ESD_R) |-> !byte_ack_o); // R7

endmodule

// File: rtl/pcs_tx_framer.sv
// Module pcs_tx_framer
// Top of the 100 Mb/s PCS transmit framer. It turns a byte-wide MAC frame
// into a registered 5-bit code-group stream, one per nibble clock, with
// J/K and T/R delimiters and idle fill. Assumes a single clock domain and
// that the scrambler follows directly on cg_out.
module pcs_tx_framer
    import pcs_txf_pkg::*;
#(
    parameter int MIN_IDLE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [BYTE_W-1:0] frm_byte,
    output logic              byte_ack,
    output logic [CG_W-1:0]   cg_out,
    output logic              cg_vld
);

    cg_sel_e          sel;
    logic             load;
    logic [NIB_W-1:0] nib;
    logic [CG_W-1:0]  data_cg;
    logic [CG_W-1:0]  cg_d;
    logic [CG_W-1:0]  cg_q;
    logic             vld_q;

    pcs_txf_seq #(.MIN_IDLE(MIN_IDLE)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_valid_i (frm_valid),
        .byte_ack_o  (byte_ack),
        .load_o      (load),
        .sel_o       (sel)
    );

    pcs_txf_nib nib_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .hi_sel_i (sel == SEL_HI),
        .byte_i   (frm_byte),
        .nib_o    (nib)
    );

    pcs_txf_enc enc_i (
        .nib_i (nib),
        .cg_o  (data_cg)
    );

    // Pick a control or data code-group for the next cycle
    always_comb begin
        unique case (sel)
            SEL_J:         cg_d = CG_J;
            SEL_K:         cg_d = CG_K;
            SEL_T:         cg_d = CG_T;
            SEL_R:         cg_d = CG_R;
            SEL_LO, SEL_HI: cg_d = data_cg;
            default:       cg_d = CG_IDLE;
        endcase
    end

    // Output register for the code-group and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cg_q  <= CG_IDLE;
            vld_q <= 1'b0;
        end else begin
            cg_q  <= cg_d;
            vld_q <= 1'b1;
        end
    end

    assign cg_out = cg_q;
    assign cg_vld = vld_q;

    AST_J_THEN_K: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_q == CG_J) |=> (cg_q == CG_K)); // R3
    AST_T_THEN_R: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_q == CG_T) |=> (cg_q == CG_R)); // R6
    AST_R_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cg_q == CG_R) |=> (cg_q == CG_IDLE)); // R7
    AST_VLD_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> vld_q); // R8

endmodule

// File: tb/pcs_tx_framer_tb_top.sv
// Directed bench for pcs_tx_framer. Inputs are driven and outputs sampled
// on the falling clock edge.
module pcs_tx_framer_tb_top;

    localparam int MIN_IDLE = 1;
    localparam logic [4:0] I_CG = 5'b11111;
    localparam logic [4:0] J_CG = 5'b11000;
    localparam logic [4:0] K_CG = 5'b10001;
    localparam logic [4:0] T_CG = 5'b01101;
    localparam logic [4:0] R_CG = 5'b00111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_valid = 1'b0;
    logic [7:0] frm_byte = 8'h00;
    logic       byte_ack;
    logic [4:0] cg_out;
    logic       cg_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] fb [64];

    always #5 clk = ~clk;

    pcs_tx_framer #(.MIN_IDLE(MIN_IDLE)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_byte  (frm_byte),
        .byte_ack  (byte_ack),
        .cg_out    (cg_out),
        .cg_vld    (cg_vld)
    );

    function automatic logic [4:0] enc_ref(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one frame of nb bytes from fb[] and check the full code stream
    task automatic send_frame(input int nb, input bit b2b, output int idles);
        int sent = 0;
        int a = 0;
        int r = 0;
        bit started = 1'b0;
        idles = 0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            @(negedge clk);
            if (started) begin
                r = cyc - a;
                chk(cg_vld == 1'b1, "R8", cg_vld, 1);
                if (r == 1)
                    chk(cg_out == J_CG, "R3", cg_out, J_CG);
                else if (r == 2)
                    chk(cg_out == K_CG, "R3", cg_out, K_CG);
                else if (r <= 2 * nb) begin
                    logic [7:0] b = fb[(r - 1) / 2];
                    logic [4:0] e = (r % 2 == 1) ? enc_ref(b[3:0]) : enc_ref(b[7:4]);
                    chk(cg_out == e, "R4", cg_out, e);
                end else if (r == 2 * nb + 1)
                    chk(cg_out == T_CG, "R6 R10", cg_out, T_CG);
                else
                    chk(cg_out == R_CG, "R6", cg_out, R_CG);
            end else begin
                chk(cg_out == I_CG, "R2", cg_out, I_CG);
                idles++;
            end
            if (started && sent == nb) begin
                frm_valid = b2b && (r >= 2 * nb + 1);
                frm_byte  = 8'h55;
            end else begin
                frm_valid = (sent < nb);
                frm_byte  = fb[sent];
            end
            #1;
            if (started) begin
                bit e_ack = (r % 2 == 0) && (r <= 2 * (nb - 1));
                chk(byte_ack == e_ack, (r > 2 * nb) ? "R7" : "R5", byte_ack, e_ack);
            end
            if (byte_ack) begin
                if (!started) begin
                    started = 1'b1;
                    a = cyc;
                end
                sent++;
            end
            if (started && (cyc - a) == 2 * nb + 2) break;
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        frm_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(cg_out == I_CG, "R1", cg_out, I_CG);
        chk(cg_vld == 1'b0, "R1", cg_vld, 0);
        chk(byte_ack == 1'b0, "R1", byte_ack, 0);
        rst_n = 1'b1;
    endtask

    task automatic test_idle();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk(cg_out == I_CG, "R2", cg_out, I_CG);
            chk(byte_ack == 1'b0, "R2", byte_ack, 0);
            if (i > 0) chk(cg_vld == 1'b1, "R8", cg_vld, 1);
        end
    endtask

    task automatic test_preamble_frame();
        int idl;
        for (int i = 0; i < 7; i++) fb[i] = 8'h55;
        fb[7] = 8'hD5;
        for (int i = 8; i < 20; i++) fb[i] = 8'((i * 37 + 11) & 8'hFF);
        send_frame(20, 1'b0, idl);
    endtask

    task automatic test_all_nibbles();
        int idl;
        fb[0] = 8'h55;
        for (int i = 0; i < 8; i++) fb[i + 1] = {4'(2 * i + 1), 4'(2 * i)};
        send_frame(9, 1'b0, idl);
    endtask

    task automatic test_single_byte();
        int idl;
        fb[0] = 8'hA7;
        send_frame(1, 1'b0, idl);
        @(negedge clk);
        chk(cg_out == I_CG, "R7", cg_out, I_CG);
    endtask

    task automatic test_back_to_back();
        int idl;
        fb[0] = 8'h55; fb[1] = 8'h3C; fb[2] = 8'hE1; fb[3] = 8'h0F;
        send_frame(4, 1'b1, idl);
        fb[0] = 8'h55; fb[1] = 8'h96; fb[2] = 8'h48;
        send_frame(3, 1'b0, idl);
        chk(idl == MIN_IDLE, "R7", idl, MIN_IDLE);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_idle();
        test_preamble_frame();
        test_idle();
        test_all_nibbles();
        test_single_byte();
        test_back_to_back();
        test_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule